// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block sits next to the core of a small 8-bit microcontroller and runs its two software-entered low-power states. Software writes a two-bit power-control field. One bit selects a light sleep, in which only the CPU clock is stopped. The other selects a deep sleep, in which every internal clock enable drops while register and RAM contents are retained. In each state the block drives override controls for the two external-bus strobes, and it watches the interrupt sources and the reset to decide when to resume.

The wake rules differ by state. Light sleep ends as soon as any enabled interrupt source requests service. Deep sleep ends only on an external interrupt that is both enabled and configured as level-sensitive. In deep sleep no clock runs to sample that request, so the wake is detected combinationally and the clock enables come back within the same cycle. The mode bit then clears on the next edge, when the interrupt starts service. A synchronous reset behaves like a power-on reset from either state.

Top module: `pmc_top`

## Requirements
- R1: While `rst` is high, both clock enables are 1 and no strobe override is active. A reset clears both bits of `pwr_bits` at the next edge from any state.
- R2: A write with `ctl_wdata[0]`=1 and `ctl_wdata[1]`=0 enters light sleep, shown as `pwr_bits`=01. In that state `cpu_clk_en`=0 and `per_clk_en`=1.
- R3: In light sleep, both strobe overrides are active (`stb_force_en`=11) and both forced values are high (`stb_force_val`=11).
- R4: In light sleep, a source with `irq_req` and `irq_en` both high clears `pwr_bits` at the next edge, and `cpu_clk_en` returns to 1 from that edge on. A request without its enable has no effect.
- R5: A write with `ctl_wdata[1]`=1 enters deep sleep, shown as `pwr_bits`=10. In that state, with no qualifying wake, `cpu_clk_en`=0 and `per_clk_en`=0.
- R6: In deep sleep, with no qualifying wake, both strobe overrides are active and both forced values are low (`stb_force_val`=00).
- R7: In deep sleep, a source with `irq_req`, `irq_en`, `irq_is_ext` and `irq_is_level` all high raises both clock enables and releases the overrides in the same cycle. `pwr_bits` clears at the next edge.
- R8: In deep sleep, edge-configured external sources, internal sources and disabled level sources do not change any output and leave `pwr_bits` at 10.
- R9: A write with both data bits set stores deep sleep only (`pwr_bits`=10).
- R10: Writes made while either mode bit is set are ignored.
- R11: A mode takes effect on the edge that accepts the write. In the cycle the write is presented, the clock enables are still 1 and no override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_we | input | 1 | Power-control write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| irq_req | input | NIRQ | Interrupt request per source |
| irq_en | input | NIRQ | Interrupt enable per source |
| irq_is_ext | input | NIRQ | Source is an external pin |
| irq_is_level | input | NIRQ | Source is level-sensitive |
| pwr_bits | output | 2 | Current mode bits, same encoding as the write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt-logic clock enable |
| stb_force_en | output | NSTB | Strobe override active; index 0 address latch, 1 program fetch |
| stb_force_val | output | NSTB | Level forced onto each strobe while overridden |

## Verification
The stored mode is the block's only state, and it drives every output. If the state is wrong, the clock enables and strobe overrides show it in the first cycle after the edge that stored it, and `pwr_bits` shows it directly. A deep-sleep wake that latches or loses the mode shows up in two ways. The enables and overrides change in the same cycle as the qualifying request. `pwr_bits` fails to reach 00 one edge later.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int LIGHT_BIT = 0;
    localparam int DEEP_BIT  = 1;

    typedef struct packed {
        logic deep;
        logic light;
    } pwr_ctl_t;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_LIGHT = 2'b01,
        PM_DEEP  = 2'b10
    } pm_mode_e;

    function automatic pwr_ctl_t decode_write(input logic [1:0] wd);
        pwr_ctl_t r;
        r.deep  = wd[DEEP_BIT];
        r.light = wd[LIGHT_BIT] & ~wd[DEEP_BIT];
        return r;
    endfunction

    function automatic pm_mode_e mode_of(input pwr_ctl_t c);
        if (c.deep)       return PM_DEEP;
        else if (c.light) return PM_LIGHT;
        else              return PM_RUN;
    endfunction

endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
    parameter int NIRQ = 5
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_is_ext,
    input  logic [NIRQ-1:0] irq_is_level,
    output logic            any_wake,
    output logic            deep_wake
);
    logic [NIRQ-1:0] live;
    logic [NIRQ-1:0] deep_ok;

    for (genvar i = 0; i < NIRQ; i++) begin : g_src
        assign live[i]    = irq_req[i] & irq_en[i];
        assign deep_ok[i] = live[i] & irq_is_ext[i] & irq_is_level[i];
    end

    assign any_wake  = |live;
    assign deep_wake = |deep_ok;
endmodule

// File: rtl/pmc_strobe.sv
module pmc_strobe #(
    parameter int NSTB = 2
) (
    input  logic            hold_high,
    input  logic            hold_low,
    output logic [NSTB-1:0] force_en,
    output logic [NSTB-1:0] force_val
);
    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        assign force_en[i]  = hold_high | hold_low;
        assign force_val[i] = hold_high & ~hold_low;
    end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int NIRQ = 5,
    parameter int NSTB = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_we,
    input  logic [1:0]      ctl_wdata,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_is_ext,
    input  logic [NIRQ-1:0] irq_is_level,
    output logic [1:0]      pwr_bits,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic [NSTB-1:0] stb_force_en,
    output logic [NSTB-1:0] stb_force_val
);
    pwr_ctl_t ctl_q;
    pm_mode_e mode;
    logic     any_wake, deep_wake;
    logic     deep_waking;

    pmc_wake #(.NIRQ(NIRQ)) u_wake (
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .irq_is_ext   (irq_is_ext),
        .irq_is_level (irq_is_level),
        .any_wake     (any_wake),
        .deep_wake    (deep_wake)
    );

    assign mode = mode_of(ctl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            unique case (mode)
                PM_DEEP:  if (deep_wake) ctl_q.deep  <= 1'b0;
                PM_LIGHT: if (any_wake)  ctl_q.light <= 1'b0;
                default:  if (ctl_we)    ctl_q <= decode_write(ctl_wdata);
            endcase
        end
    end

    assign deep_waking = (mode == PM_DEEP) & deep_wake;
    assign pwr_bits    = ctl_q;
    assign cpu_clk_en  = rst | (mode == PM_RUN) | deep_waking;
    assign per_clk_en  = rst | (mode != PM_DEEP) | deep_waking;

    pmc_strobe #(.NSTB(NSTB)) u_stb (
        .hold_high (~rst & (mode == PM_LIGHT)),
        .hold_low  (~rst & (mode == PM_DEEP) & ~deep_wake),
        .force_en  (stb_force_en),
        .force_val (stb_force_val)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> pwr_bits == 2'b00);
    a_r2_light_gates_cpu: assert property (@(posedge clk) disable iff (rst)
        pwr_bits == 2'b01 |-> !cpu_clk_en && per_clk_en);
    a_r3_light_strobes_high: assert property (@(posedge clk) disable iff (rst)
        pwr_bits == 2'b01 |-> (&stb_force_en) && (&stb_force_val));
    a_r4_light_exit: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b01 && any_wake) |=> pwr_bits == 2'b00);
    a_r5_deep_gates_all: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b10 && !deep_wake) |-> !cpu_clk_en && !per_clk_en);
    a_r6_deep_strobes_low: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b10 && !deep_wake) |-> (&stb_force_en) && !(|stb_force_val));
    a_r7_deep_exit: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b10 && deep_wake) |=> pwr_bits == 2'b00);
    a_r8_deep_holds: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b10 && !deep_wake) |=> pwr_bits == 2'b10);
    a_r9_deep_wins: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits == 2'b00 && ctl_we && ctl_wdata == 2'b11) |=> pwr_bits == 2'b10);
    a_r10_sleep_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (pwr_bits != 2'b00 && !any_wake) |=> $stable(pwr_bits));
endmodule

// File: tb/sim_pmc_top.sv
module sim_pmc_top;
    localparam int PERIOD = 10;
    localparam int NIRQ = 5;
    localparam int NSTB = 2;

    logic clk = 0;
    logic rst;
    logic ctl_we;
    logic [1:0] ctl_wdata;
    logic [NIRQ-1:0] irq_req, irq_en, irq_is_ext, irq_is_level;
    logic [1:0] pwr_bits;
    logic cpu_clk_en, per_clk_en;
    logic [NSTB-1:0] stb_force_en, stb_force_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_light = 0;
    int m_deep = 0;

    always #(PERIOD/2) clk = ~clk;

    pmc_top #(.NIRQ(NIRQ), .NSTB(NSTB)) u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .irq_req(irq_req), .irq_en(irq_en), .irq_is_ext(irq_is_ext),
        .irq_is_level(irq_is_level), .pwr_bits(pwr_bits),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .stb_force_en(stb_force_en), .stb_force_val(stb_force_val)
    );

    function automatic bit lvl_wake();
        for (int i = 0; i < NIRQ; i++)
            if (irq_req[i] && irq_en[i] && irq_is_ext[i] && irq_is_level[i]) return 1;
        return 0;
    endfunction

    function automatic bit any_req();
        for (int i = 0; i < NIRQ; i++)
            if (irq_req[i] && irq_en[i]) return 1;
        return 0;
    endfunction

    // behavioural reference state, advanced on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_light <= 0; m_deep <= 0;
        end else if (m_deep != 0) begin
            if (lvl_wake()) m_deep <= 0;
        end else if (m_light != 0) begin
            if (any_req()) m_light <= 0;
        end else if (ctl_we) begin
            m_deep  <= ctl_wdata[1] ? 1 : 0;
            m_light <= (ctl_wdata[0] && !ctl_wdata[1]) ? 1 : 0;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic r, input logic we, input logic [1:0] wd,
                       input logic [NIRQ-1:0] rq, input logic [NIRQ-1:0] en,
                       input logic [NIRQ-1:0] ex, input logic [NIRQ-1:0] lv);
        bit dw;
        int e_cpu, e_per, e_fe, e_fv;
        @(negedge clk);
        rst = r; ctl_we = we; ctl_wdata = wd;
        irq_req = rq; irq_en = en; irq_is_ext = ex; irq_is_level = lv;
        #1;
        dw = (m_deep != 0) && lvl_wake();
        e_cpu = (r || (m_light == 0 && m_deep == 0) || dw) ? 1 : 0;
        e_per = (r || m_deep == 0 || dw) ? 1 : 0;
        e_fe  = (!r && (m_light != 0 || (m_deep != 0 && !dw))) ? 3 : 0;
        e_fv  = (!r && m_light != 0) ? 3 : 0;
        chk(tag, "pwr_bits", int'(pwr_bits), m_deep * 2 + m_light);
        chk(tag, "cpu_clk_en", int'(cpu_clk_en), e_cpu);
        chk(tag, "per_clk_en", int'(per_clk_en), e_per);
        chk(tag, "stb_force_en", int'(stb_force_en), e_fe);
        chk(tag, "stb_force_val", int'(stb_force_val), e_fv);
    endtask

    task automatic idle_cyc(input string tag, input int n);
        for (int k = 0; k < n; k++) cyc(tag, 0, 0, 2'b00, '0, '0, '0, '0);
    endtask

    initial begin
        rst = 1; ctl_we = 0; ctl_wdata = 0;
        irq_req = 0; irq_en = 0; irq_is_ext = 0; irq_is_level = 0;
        for (int k = 0; k < 3; k++) cyc("R1", 1, 0, 2'b00, '0, '0, '0, '0);
        idle_cyc("R1", 2);
        // light sleep entry: write cycle still running (R11)
        cyc("R11", 0, 1, 2'b01, '0, '0, '0, '0);
        idle_cyc("R2", 2);
        idle_cyc("R3", 1);
        // disabled request and a write while asleep
        cyc("R4", 0, 0, 2'b00, 5'b00100, 5'b00000, '0, '0);
        cyc("R10", 0, 1, 2'b10, '0, '0, '0, '0);
        idle_cyc("R10", 1);
        // enabled internal request exits light sleep
        cyc("R4", 0, 0, 2'b00, 5'b00100, 5'b00100, '0, '0);
        idle_cyc("R4", 2);
        // deep sleep entry
        cyc("R11", 0, 1, 2'b10, '0, '0, '0, '0);
        idle_cyc("R5", 2);
        idle_cyc("R6", 1);
        // rejected wakes: edge external, internal, disabled level external
        cyc("R8", 0, 0, 2'b00, 5'b00001, 5'b00001, 5'b00001, 5'b00000);
        cyc("R8", 0, 0, 2'b00, 5'b10000, 5'b10000, 5'b00000, 5'b10000);
        cyc("R8", 0, 0, 2'b00, 5'b00010, 5'b00000, 5'b00010, 5'b00010);
        cyc("R10", 0, 1, 2'b01, '0, '0, '0, '0);
        idle_cyc("R8", 2);
        // accepted level wake
        cyc("R7", 0, 0, 2'b00, 5'b00010, 5'b00010, 5'b00011, 5'b00010);
        idle_cyc("R7", 2);
        // both bits set
        cyc("R9", 0, 1, 2'b11, '0, '0, '0, '0);
        idle_cyc("R9", 2);
        // edge request also wakes light sleep? no: deep here, ensure reset exit
        cyc("R1", 1, 0, 2'b00, '0, '0, '0, '0);
        idle_cyc("R1", 2);
        cyc("R2", 0, 1, 2'b01, '0, '0, '0, '0);
        idle_cyc("R2", 1);
        // edge external source wakes light sleep
        cyc("R4", 0, 0, 2'b00, 5'b00001, 5'b00001, 5'b00001, 5'b00000);
        idle_cyc("R4", 1);
        cyc("R2", 0, 1, 2'b01, '0, '0, '0, '0);
        cyc("R1", 1, 0, 2'b00, '0, '0, '0, '0);
        idle_cyc("R1", 2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule